// File: doc/BRIEF.md
# Debug Abstract Register-Transfer Unit

This unit sits inside a processor debug module and runs register-transfer commands on behalf of an external debugger while the hart is halted. A debugger writes an argument word, optional program-buffer words and then a command word over a small register-write interface. The unit copies a value between a 32-bit argument register and one entry of a modelled file of 32 general registers. General register n is reached at abstract number 0x1000 + n. Any other number, including the CSR range 0x0000 to 0x0FFF, is refused, because only general registers can be moved this way.

Memory cannot be reached by a transfer alone. For that, the debugger loads a short routine, ending in ebreak, into the program buffer and sets the post-execute bit. After the transfer, the unit pulses a start request to an external executor. It stays busy until the executor reports that ebreak was reached. Errors are reported through a sticky three-bit code that software clears by writing ones.

Top module: `dbg_regxfer_unit`

## Requirements
- R1: After reset, busy, exec_start and cmderr are 0, the argument register reads 0, and every general register holds 0.
- R2: A command write (address 1) is accepted when the unit is idle, cmderr is 0 and the command is legal. The command fields are: type [31:24] = 0, size [22:20] = 2, post-execute bit 18, transfer bit 17, write bit 16, regno [15:0]. Once accepted, busy is 1 from the next edge. Without post-execute, busy returns to 0 one edge later. With transfer set and write clear, the register at regno 0x1000 + n (n = 0..31) is copied into the argument register at that second edge.
- R3: With transfer and write both set, the argument register is copied into general register n at the second edge.
- R4: General register 0 always reads back 0; writes to it are discarded.
- R5: A command write with transfer set and a regno outside 0x1000 to 0x101F (including CSR numbers such as 0x300), or with size other than 2, or with any type other than 0, sets cmderr to 2 at the next edge. It performs no transfer and never raises busy. With transfer clear, regno and size are not checked.
- R6: While cmderr is nonzero, command writes are ignored: no busy, no transfer.
- R7: cmderr keeps its value until a write to the status address (2) clears exactly the bits written as ones in [10:8]. Reading address 2 returns busy in bit 12 and cmderr in [10:8].
- R8: With post-execute set, exec_start is a one-cycle pulse starting at the edge that ends the transfer. busy then stays 1 until the edge at which exec_done is sampled high. exec_done has no effect at any other time.
- R9: While busy, writes to the argument register, the command address or a program-buffer address are dropped. Such a write sets cmderr to 1 if cmderr was 0.
- R10: The argument register (address 0) and the program-buffer words (address 4 + i) can be written in any order before the command. They read back at those addresses, and word i appears on pbuf_words[32i+31:32i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address: 0 argument, 1 command, 2 status, 4+i program buffer |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read address (same map; command reads 0) |
| rd_data | output | 32 | Combinational read data |
| busy | output | 1 | A command is running |
| cmderr | output | 3 | Sticky error: 0 none, 1 busy, 2 not supported |
| exec_start | output | 1 | One-cycle start request to the program-buffer executor |
| exec_done | input | 1 | Executor reached ebreak |
| pbuf_words | output | 32*PB_WORDS | Program-buffer contents for the executor |

## Verification
A corrupted control state would show at once on busy, and a latched command that is wrong would show as a wrong exec_start pulse or as a wrong argument value on the read port. Both appear within two cycles of the command write. A wrong register-file entry stays hidden until a later read command names it, so the bench writes and then reads back registers x0, x8 and x31. Error handling is exposed on cmderr in the cycle after each refused or colliding write, and its stickiness is checked against partial clears.

// File: rtl/dbg_regxfer_unit.sv
module dbg_regxfer_unit #(
  parameter int          NREG     = 32,
  parameter int          PB_WORDS = 2,
  parameter logic [15:0] GPR_BASE = 16'h1000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [2:0]              wr_addr,
  input  logic [31:0]             wr_data,
  input  logic [2:0]              rd_addr,
  output logic [31:0]             rd_data,
  output logic                    busy,
  output logic [2:0]              cmderr,
  output logic                    exec_start,
  input  logic                    exec_done,
  output logic [32*PB_WORDS-1:0]  pbuf_words
);
  localparam int IDXW = $clog2(NREG);
  localparam int PBW  = (PB_WORDS > 1) ? $clog2(PB_WORDS) : 1;
  localparam logic [2:0] A_DATA0 = 3'd0, A_CMD = 3'd1, A_STAT = 3'd2;

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_WAIT} st_t;
  st_t st;

  logic [31:0] data0;
  logic [31:0] rf [NREG];
  logic [31:0] pb [PB_WORDS];
  logic        x_xfer, x_write, x_post;
  logic [IDXW-1:0] x_idx;

  wire [15:0] rel    = wr_data[15:0] - GPR_BASE;
  wire        gpr_ok = (wr_data[15:0] >= GPR_BASE) && (rel < 16'(NREG));
  wire        cmd_ok = (wr_data[31:24] == 8'd0) &&
                       (!wr_data[17] || (wr_data[22:20] == 3'd2 && gpr_ok));
  wire        wr_pb  = wr_addr[2] && ({30'd0, wr_addr[1:0]} < 32'(PB_WORDS));
  wire        guarded = wr_en && (wr_addr == A_DATA0 || wr_addr == A_CMD || wr_pb);
  wire        is_cmd = wr_en && wr_addr == A_CMD;
  wire        accept = is_cmd && !busy && cmderr == 3'd0 && cmd_ok;

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cmderr     <= 3'd0;
      data0      <= '0;
      exec_start <= 1'b0;
      x_xfer     <= 1'b0;
      x_write    <= 1'b0;
      x_post     <= 1'b0;
      x_idx      <= '0;
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
      for (int i = 0; i < PB_WORDS; i++) pb[i] <= '0;
    end else begin
      if (guarded && busy) begin
        if (cmderr == 3'd0) cmderr <= 3'd1;
      end else if (is_cmd && cmderr == 3'd0 && !cmd_ok) begin
        cmderr <= 3'd2;
      end else if (wr_en && wr_addr == A_STAT) begin
        cmderr <= cmderr & ~wr_data[10:8];
      end

      if (wr_en && !busy && wr_addr == A_DATA0) data0 <= wr_data;
      if (wr_en && !busy && wr_pb) pb[wr_addr[PBW-1:0]] <= wr_data;

      case (st)
        S_IDLE: if (accept) begin
          x_xfer  <= wr_data[17];
          x_write <= wr_data[16];
          x_post  <= wr_data[18];
          x_idx   <= rel[IDXW-1:0];
          st      <= S_XFER;
        end
        S_XFER: begin
          if (x_xfer) begin
            if (x_write) begin
              if (x_idx != '0) rf[x_idx] <= data0;
            end else begin
              data0 <= rf[x_idx];
            end
          end
          if (x_post) begin
            st         <= S_WAIT;
            exec_start <= 1'b1;
          end else begin
            st <= S_IDLE;
          end
        end
        S_WAIT: begin
          exec_start <= 1'b0;
          if (exec_done) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_DATA0: rd_data = data0;
      A_STAT:  rd_data = {19'd0, busy, 1'b0, cmderr, 8'd0};
      default: if (rd_addr[2] && ({30'd0, rd_addr[1:0]} < 32'(PB_WORDS)))
                 rd_data = pb[rd_addr[PBW-1:0]];
    endcase
  end

  for (genvar g = 0; g < PB_WORDS; g++) begin : g_pb
    assign pbuf_words[32*g +: 32] = pb[g];
  end

  AST_START_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    exec_start |-> busy); // R8
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    exec_start |=> !exec_start); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmderr != 3'd0 && !(wr_en && wr_addr == A_STAT)) |=> cmderr == $past(cmderr)); // R7
  AST_ERR_BLOCKS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmderr != 3'd0) |=> !busy); // R6
  AST_BUSY_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && is_cmd && cmderr == 3'd0) |=> cmderr == 3'd1); // R9
  AST_WAIT_KEEPS_DATA0: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT) |=> data0 == $past(data0)); // R9
  AST_X0_STAYS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_XFER && x_xfer && x_write && x_idx == '0) |=> rf[0] == 32'd0); // R4
endmodule

// File: tb/tb_dbg_regxfer_unit.sv
module tb_dbg_regxfer_unit;
  localparam int PERIOD = 10;

  logic        clk = 0, rst_n = 0, wr_en = 0, exec_done = 0;
  logic [2:0]  wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] rd_data;
  logic        busy, exec_start;
  logic [2:0]  cmderr;
  logic [63:0] pbuf_words;

  int checks = 0, fails = 0;

  dbg_regxfer_unit dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .cmderr(cmderr),
    .exec_start(exec_start), .exec_done(exec_done), .pbuf_words(pbuf_words));

  always #(PERIOD/2) clk = ~clk;

  // behavioural reference
  int          m_st;
  bit          m_start, m_x, m_w, m_p, m_acc;
  int          m_idx;
  logic [31:0] m_d0;
  logic [31:0] m_rf [32];
  logic [31:0] m_pb [2];
  logic [2:0]  m_err;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_start = 0; m_d0 = 0; m_err = 0;
      foreach (m_rf[i]) m_rf[i] = 0;
      m_pb[0] = 0; m_pb[1] = 0;
    end else begin
      bit bb, pbh, legal;
      int rg;
      bb = (m_st != 0);
      m_acc = 0;
      pbh = (wr_addr == 4 || wr_addr == 5);
      if (wr_en) begin
        if (bb && (wr_addr == 0 || wr_addr == 1 || pbh)) begin
          if (m_err == 0) m_err = 1;
        end else if (wr_addr == 2) m_err = m_err & ~wr_data[10:8];
        else if (wr_addr == 0) m_d0 = wr_data;
        else if (pbh) m_pb[wr_addr - 4] = wr_data;
        else if (wr_addr == 1 && m_err == 0) begin
          rg = int'(wr_data[15:0]);
          legal = (wr_data[31:24] == 0) &&
                  (!wr_data[17] || (wr_data[22:20] == 2 && rg >= 4096 && rg < 4128));
          if (legal) begin
            m_acc = 1; m_x = wr_data[17]; m_w = wr_data[16]; m_p = wr_data[18];
            m_idx = rg - 4096;
          end else m_err = 2;
        end
      end
      if (m_st == 1) begin
        if (m_x) begin
          if (m_w) begin if (m_idx != 0) m_rf[m_idx] = m_d0; end
          else m_d0 = m_rf[m_idx];
        end
        if (m_p) begin m_st = 2; m_start = 1; end else m_st = 0;
      end else if (m_st == 2) begin
        m_start = 0;
        if (exec_done) m_st = 0;
      end
      if (m_acc) m_st = 1;
    end
  end

  function automatic logic [31:0] m_rd(input logic [2:0] a);
    case (a)
      0: return m_d0;
      2: return {19'd0, m_st != 0, 1'b0, m_err, 8'd0};
      4: return m_pb[0];
      5: return m_pb[1];
      default: return 0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #(PERIOD/4);
    if (rst_n) begin
      chk(busy == (m_st != 0), "R2 busy vs model", 32'(busy), 32'(m_st != 0));
      chk(cmderr == m_err, "R7 cmderr vs model", 32'(cmderr), 32'(m_err));
      chk(exec_start == m_start, "R8 exec_start vs model", 32'(exec_start), 32'(m_start));
      chk(rd_data == m_rd(rd_addr), "R10 rd_data vs model", rd_data, m_rd(rd_addr));
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); rd_addr = a; #1;
    chk(rd_data == exp, tag, rd_data, exp);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog expired actual=hung expected=done");
    summary();
  end

  initial begin
    idle(3); rst_n = 1; idle(1);
    chk(busy == 0 && exec_start == 0, "R1 reset busy/start", {busy, exec_start}, 0);
    chk(cmderr == 0, "R1 reset cmderr", 32'(cmderr), 0);
    rd(0, 0, "R1 reset data0");

    // R3 write x8, R2 read back
    wr(0, 32'hDEADBEEF);
    wr(1, 32'h0023_1008);
    chk(busy == 1, "R2 busy after command", 32'(busy), 1);
    idle(1);
    chk(busy == 0, "R2 busy one cycle", 32'(busy), 0);
    wr(0, 0);
    wr(1, 32'h0022_1008); idle(1);
    rd(0, 32'hDEADBEEF, "R3 x8 written then read");

    // R4 x0
    wr(0, 32'h1234); wr(1, 32'h0023_1000); idle(1);
    wr(0, 5); wr(1, 32'h0022_1000); idle(1);
    rd(0, 0, "R4 x0 reads zero");

    // x31 boundary
    wr(0, 32'hA5A5_0001); wr(1, 32'h0023_101F); idle(1);
    wr(0, 0); wr(1, 32'h0022_101F); idle(1);
    rd(0, 32'hA5A5_0001, "R2 x31 round trip");

    // R5 CSR refused
    wr(0, 32'h77); wr(1, 32'h0022_0300);
    chk(busy == 0, "R5 csr no busy", 32'(busy), 0);
    chk(cmderr == 2, "R5 csr not supported", 32'(cmderr), 2);
    rd(0, 32'h77, "R5 csr no transfer");
    // R6 ignored while error
    wr(1, 32'h0022_1008);
    chk(busy == 0, "R6 command ignored under error", 32'(busy), 0);
    idle(1);
    rd(0, 32'h77, "R6 no transfer under error");
    // R7 partial then full clear
    wr(2, 32'h100);
    chk(cmderr == 2, "R7 partial clear keeps code", 32'(cmderr), 2);
    rd(2, 32'h200, "R7 status layout");
    wr(2, 32'h700);
    chk(cmderr == 0, "R7 full clear", 32'(cmderr), 0);

    wr(1, 32'h0032_1008);
    chk(cmderr == 2, "R5 bad size", 32'(cmderr), 2);
    wr(2, 32'h700);
    wr(1, 32'h0100_0000);
    chk(cmderr == 2, "R5 bad type", 32'(cmderr), 2);
    wr(2, 32'h700);
    wr(1, 32'h0022_1020);
    chk(cmderr == 2, "R5 regno past x31", 32'(cmderr), 2);
    wr(2, 32'h700);
    wr(1, 32'h0000_0300);
    chk(busy == 1 && cmderr == 0, "R5 no-transfer skips regno check", {busy, cmderr}, 32'h8);
    idle(1);

    // R10 any-order loading, R8 post-execute
    wr(5, 32'h0010_0073);
    wr(0, 32'h1);
    wr(4, 32'h0004_A403);
    chk(pbuf_words == 64'h0010_0073_0004_A403, "R10 pbuf_words", pbuf_words[31:0], 32'h0004_A403);
    rd(5, 32'h0010_0073, "R10 pbuf word 1 read");
    wr(1, 32'h0026_1008);
    chk(busy == 1 && exec_start == 0, "R8 busy before start", {busy, exec_start}, 2);
    idle(1);
    chk(exec_start == 1, "R8 start pulse", 32'(exec_start), 1);
    rd(0, 32'hDEADBEEF, "R8 transfer before start");
    chk(exec_start == 0 && busy == 1, "R8 start single cycle, still busy", {busy, exec_start}, 2);
    // R9 collisions
    wr(0, 32'h99);
    chk(cmderr == 1, "R9 busy error", 32'(cmderr), 1);
    wr(1, 32'h0022_1000);
    wr(4, 32'h0);
    rd(0, 32'hDEADBEEF, "R9 data0 write dropped");
    rd(4, 32'h0004_A403, "R9 pbuf write dropped");
    idle(3);
    chk(busy == 1, "R8 busy held until done", 32'(busy), 1);
    @(negedge clk); exec_done = 1;
    @(negedge clk); exec_done = 0;
    chk(busy == 0, "R8 done ends busy", 32'(busy), 0);
    wr(2, 32'h700);
    @(negedge clk); exec_done = 1;
    @(negedge clk); exec_done = 0;
    chk(busy == 0 && exec_start == 0, "R8 stray done ignored", {busy, exec_start}, 0);
    idle(2);
    summary();
  end
endmodule